// File: doc/BRIEF.md
# Configuration Image Checksum Builder

This block prepares a 64-word by 16-bit configuration image for a network controller. Software or a boot sequencer first fills a template store through a simple write port. A start strobe then copies the template into the image store one word per cycle. During the copy, the block patches in the station address and the device identifier.

While copying, the block adds up every word it writes. It then closes the image with a checksum word chosen so that all 64 words sum to 0xBABA modulo 2^16. A one-cycle done pulse marks the finished image. The result is read back through a registered word read port.

Top module: `eeprom_image_builder`

## Requirements
- R1: After reset, `done` is low, and it stays low until a build has been started and has finished.
- R2: The 48-bit station address `mac_addr` is read as six bytes, with byte 0 in bits 47:40 and byte 5 in bits 7:0. Image word k (k = 0, 1, 2) holds byte 2k in bits 7:0 and byte 2k+1 in bits 15:8.
- R3: Image words 11 and 13 both hold `dev_id`.
- R4: Every other image word from 0 to 62 equals the template word at the same index.
- R5: Image word 63 equals 0xBABA minus the 16-bit sum of image words 0 to 62, as patched. A template value written at index 63 has no effect on the image.
- R6: If `start` is sampled high at clock edge E0, `done` is high for exactly one cycle, following clock edge E0+64.
- R7: A `start` pulse that arrives during a build is ignored, so the `done` timing of that build is unchanged.
- R8: `rd_data` returns the image word at `rd_addr` one clock after the address is presented.
- R9: Asserting reset during a build abandons the build. No `done` pulse follows, and a later start builds a complete image.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Build request strobe |
| tpl_we | input | 1 | Template word write enable |
| tpl_addr | input | 6 | Template word index |
| tpl_data | input | 16 | Template word value |
| mac_addr | input | 48 | Station address, byte 0 in bits 47:40 |
| dev_id | input | 16 | Device identifier |
| rd_addr | input | 6 | Image word index to read |
| rd_data | output | 16 | Registered image word |
| done | output | 1 | One-cycle build-complete pulse |

## Verification
The bound checker covers the control timing on every cycle:
- `done` never lasts beyond one cycle.
- `done` only follows a build.
- The internal build window stays open for exactly 64 cycles, whatever happens on `start` meanwhile.

The image contents cannot be checked by the checker and are left to the bench scenarios. These cover address byte placement, the duplicated identifier, template pass-through and the closing checksum. The bench compares the image against its own model for several templates and addresses. It also covers abandoning a build through reset.

// File: rtl/eeprom_image_builder.sv
module eeprom_image_builder #(
  parameter int WORDS = 64,
  parameter logic [15:0] CSUM_K = 16'hBABA,
  parameter int ID_A = 11,
  parameter int ID_B = 13
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        tpl_we,
  input  logic [5:0]  tpl_addr,
  input  logic [15:0] tpl_data,
  input  logic [47:0] mac_addr,
  input  logic [15:0] dev_id,
  input  logic [5:0]  rd_addr,
  output logic [15:0] rd_data,
  output logic        done
);
  localparam int AW = $clog2(WORDS);
  localparam int LAST = WORDS - 1;

  logic [15:0] tpl_mem [WORDS];
  logic [15:0] img_mem [WORDS];
  logic        busy;
  logic [AW-1:0] idx;
  logic [15:0] acc;
  logic [15:0] word;

  wire at_end = (idx == AW'(LAST));

  always_comb begin
    word = tpl_mem[idx];
    if (idx == AW'(0)) word = {mac_addr[39:32], mac_addr[47:40]};
    else if (idx == AW'(1)) word = {mac_addr[23:16], mac_addr[31:24]};
    else if (idx == AW'(2)) word = {mac_addr[7:0], mac_addr[15:8]};
    else if (idx == AW'(ID_A) || idx == AW'(ID_B)) word = dev_id;
    if (at_end) word = CSUM_K - acc;
  end

  always_ff @(posedge clk) begin
    if (tpl_we) tpl_mem[tpl_addr] <= tpl_data;
    if (busy) img_mem[idx] <= word;
    rd_data <= img_mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      idx  <= '0;
      acc  <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          idx  <= '0;
          acc  <= '0;
        end
      end else if (at_end) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        acc <= acc + word;
        idx <= idx + 1'b1;
      end
    end
  end
endmodule

module image_builder_chk #(
  parameter int WORDS = 64
) (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done
);
  localparam int CW = $clog2(WORDS) + 2;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (busy) cnt <= cnt + 1'b1;
    else cnt <= '0;
  end

  // R6
  done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R1
  done_after_build_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt < CW'(WORDS - 1)) |=> busy);

  // R6
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(busy)) |-> (cnt == CW'(WORDS)));
endmodule

bind eeprom_image_builder image_builder_chk #(.WORDS(WORDS)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done)
);

// File: tb/eeprom_image_builder_test.sv
module eeprom_image_builder_test;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic tpl_we = 1'b0;
  logic [5:0] tpl_addr = '0;
  logic [15:0] tpl_data = '0;
  logic [47:0] mac_addr = '0;
  logic [15:0] dev_id = '0;
  logic [5:0] rd_addr = '0;
  logic [15:0] rd_data;
  logic done;

  int n_tot = 0;
  int n_pass = 0;
  bit finished = 0;
  logic [15:0] tpl [64];
  logic [15:0] exp_img [64];

  always #(PERIOD/2) clk = ~clk;

  eeprom_image_builder uut (
    .clk(clk), .rst_n(rst_n), .start(start), .tpl_we(tpl_we),
    .tpl_addr(tpl_addr), .tpl_data(tpl_data), .mac_addr(mac_addr),
    .dev_id(dev_id), .rd_addr(rd_addr), .rd_data(rd_data), .done(done)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_tot++;
    if (ok) n_pass++;
    else $display("FAIL %s actual=%h expected=%h", req, act, expv);
  endtask

  task automatic load_tpl();
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      tpl_we = 1'b1; tpl_addr = 6'(i); tpl_data = tpl[i];
    end
    @(negedge clk);
    tpl_we = 1'b0;
  endtask

  task automatic model();
    logic [15:0] s;
    s = '0;
    for (int i = 0; i < 63; i++) begin
      exp_img[i] = tpl[i];
      if (i < 3) exp_img[i] = {mac_addr[47-16*i-8 -: 8], mac_addr[47-16*i -: 8]};
      if (i == 11 || i == 13) exp_img[i] = dev_id;
      s = s + exp_img[i];
    end
    exp_img[63] = 16'hBABA - s;
  endtask

  task automatic run_build(input bit poke, output int n);
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (n < 200) begin
      @(posedge clk);
      @(negedge clk);
      n++;
      if (poke && (n == 5 || n == 40 || n == 63)) start = 1'b1;
      else start = 1'b0;
      if (done) break;
    end
    start = 1'b0;
  endtask

  task automatic read_word(input int a, output logic [15:0] v);
    @(negedge clk);
    rd_addr = 6'(a);
    @(posedge clk);
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic check_image(input string tag);
    logic [15:0] v;
    logic [15:0] total;
    bit ok2 = 1, ok3 = 1, ok4 = 1;
    total = '0;
    for (int i = 0; i < 64; i++) begin
      read_word(i, v);
      total = total + v;
      if (i < 3 && v !== exp_img[i]) begin
        ok2 = 0; chk(0, {"R2 ", tag}, 32'(v), 32'(exp_img[i]));
      end
      if ((i == 11 || i == 13) && v !== exp_img[i]) begin
        ok3 = 0; chk(0, {"R3 ", tag}, 32'(v), 32'(exp_img[i]));
      end
      if (i >= 3 && i < 63 && i != 11 && i != 13 && v !== exp_img[i]) begin
        ok4 = 0; chk(0, {"R4 ", tag}, 32'(v), 32'(exp_img[i]));
      end
      if (i == 63) chk(v === exp_img[63], {"R5 checksum word ", tag}, 32'(v), 32'(exp_img[63]));
    end
    if (ok2) chk(1, "R2", 0, 0);
    if (ok3) chk(1, "R3", 0, 0);
    if (ok4) chk(1, "R4", 0, 0);
    chk(total === 16'hBABA, {"R5 image sum R8 readback ", tag}, 32'(total), 32'hBABA);
  endtask

  task automatic build_and_check(input string tag, input bit poke);
    int n;
    model();
    run_build(poke, n);
    chk(n == 64, poke ? "R7 done timing with extra starts" : "R6 done timing", n, 64);
    @(negedge clk);
    chk(done === 1'b0, "R6 done one cycle", 32'(done), 0);
    check_image(tag);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(done === 1'b0, "R1 done low in reset", 32'(done), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(done === 1'b0, "R1 done low after reset", 32'(done), 0);
  endtask

  task automatic t_basic();
    for (int i = 0; i < 64; i++) tpl[i] = 16'(16'h1000 + i * 16'h0123);
    mac_addr = 48'h52_54_00_12_34_56;
    dev_id = 16'h100E;
    load_tpl();
    build_and_check("basic", 0);
  endtask

  task automatic t_ones();
    for (int i = 0; i < 64; i++) tpl[i] = 16'hFFFF;
    mac_addr = 48'hA1_B2_C3_D4_E5_F6;
    dev_id = 16'hBEEF;
    load_tpl();
    build_and_check("ones", 0);
  endtask

  task automatic t_zero_busy();
    for (int i = 0; i < 64; i++) tpl[i] = (i == 63) ? 16'h5A5A : 16'h0000;
    mac_addr = 48'h0;
    dev_id = 16'h0;
    load_tpl();
    build_and_check("zero", 1);
  endtask

  task automatic t_mid_reset();
    bit seen = 0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(done === 1'b0, "R9 done low on abort", 32'(done), 0);
    rst_n = 1'b1;
    repeat (80) begin
      @(negedge clk);
      if (done) seen = 1;
    end
    chk(!seen, "R9 no done after abort", 32'(seen), 0);
    for (int i = 0; i < 64; i++) tpl[i] = 16'(i * 16'h0F0F ^ 16'h3C3C);
    mac_addr = 48'h02_00_5E_10_20_30;
    dev_id = 16'h10D3;
    load_tpl();
    build_and_check("after abort R9", 0);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_ones();
    t_zero_busy();
    t_mid_reset();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_pass, n_tot);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 150000);
    if (!finished) begin
      finished = 1;
      chk(0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", n_pass, n_tot);
      $finish;
    end
  end
endmodule